// File: doc/BRIEF.md
# Physical Register Wakeup Scoreboard

This block keeps one ready bit for every physical register and holds the source operand state of each issue-queue entry. Rename writes an entry through the insert port. The insert carries the entry slot, the source register tags with the ready hints that rename already knows, and an optional destination tag. Execution reports finished producers on a completion port that takes two destination tags per cycle. Each waiting source that matches a completing tag becomes ready on the next cycle, and the scoreboard bit for that register is set.

Dependents are not kept as linked lists. Each entry stores its source tags together with a wait bit for each source, and every completion tag is compared against all stored tags in parallel. A source that rename flagged as not ready is checked against the scoreboard at insert time, so a wakeup that happened while the instruction was in flight is not lost. A completion in the same cycle as the insert is bypassed. Tags at or above the physical register count are outside the register file and are never tracked. Squashing an entry drops it, together with its dependencies. The block also reports how many entries were woken in the current cycle, and it flags an insert that names a producer for a register that still has dependents.

Top module: `wakeup_scoreboard`

## Requirements
- R1: After reset, all scoreboard bits are not-ready and no entry is valid, so every bit of src_rdy and ent_rdy is 0.
- R2: An insert with ins_dst_vld and a tracked ins_dst_tag clears that register's scoreboard bit from the next cycle. If a completion names the same register in the same cycle, the clear wins.
- R3: An inserted source shows ready on src_rdy in the next cycle when its ins_src_rdy bit is 1, or when the scoreboard bit for its tag is already set. Otherwise the source waits.
- R4: A tag greater than or equal to NUM_PREGS is untracked. Such a source is ready at insert, a completion with such a tag wakes nothing and sets no bit, and such a destination clears nothing.
- R5: A valid completion lane (cmp_vld[k], tag in cmp_tag bits k*TAG_W upward) with a tracked tag does two things: it makes every waiting source holding that tag ready on the next cycle, and it sets the register's scoreboard bit.
- R6: A source inserted in the same cycle as a completion of its tag is ready on the next cycle and does not wait.
- R7: prod_err is 1 in the cycle of an insert that has ins_dst_vld and a tracked destination tag while a valid entry outside the squash mask still waits on that tag and is not woken in the same cycle.
- R8: squash[e] invalidates entry e on the next cycle, and its sources stop counting as dependents. An insert to the same slot in the same cycle takes precedence.
- R9: ent_rdy[e] is 1 exactly when entry e is valid and all of its sources are ready. src_rdy bit e*NUM_SRC+s is 1 when entry e is valid and source s is not waiting.
- R10: wake_cnt equals the number of valid entries with at least one waiting source that matches a valid tracked completion tag in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_vld | input | 1 | Insert an entry this cycle |
| ins_idx | input | IDX_W | Slot written by the insert |
| ins_src_tag | input | NUM_SRC*TAG_W | Source tags, source s at bits s*TAG_W upward |
| ins_src_rdy | input | NUM_SRC | Rename already knows the source is ready |
| ins_dst_vld | input | 1 | Insert carries a destination register |
| ins_dst_tag | input | TAG_W | Destination tag of the inserted entry |
| cmp_vld | input | NUM_CMP | Completion lane valid |
| cmp_tag | input | NUM_CMP*TAG_W | Completed destination tags |
| squash | input | NUM_ENT | Entries to remove |
| src_rdy | output | NUM_ENT*NUM_SRC | Per-source ready, bit e*NUM_SRC+s |
| ent_rdy | output | NUM_ENT | Entry valid with all sources ready |
| wake_cnt | output | CNT_W | Entries woken this cycle |
| prod_err | output | 1 | Insert names a producer whose register still has dependents |

## Verification
Four properties are checked on every cycle by assertions: a matching completion always readies a waiting source, the scoreboard follows inserts and completions, no untracked tag is ever left waiting, and a ready entry stays ready until it is squashed or overwritten. Some behaviours need a reference model to show: the insert-time scoreboard check, the same-cycle bypass, the priority between a destination clear and a completion, and the exact wake count and producer-error value under mixed traffic. The bench covers these with directed scenarios and a randomized run, and compares every output with a behavioural model on each cycle.

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard #(
  parameter int NUM_PREGS = 16,
  parameter int NUM_ENT   = 8,
  parameter int NUM_SRC   = 2,
  parameter int NUM_CMP   = 2,
  localparam int TAG_W = $clog2(NUM_PREGS) + 1,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int CNT_W = $clog2(NUM_ENT + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_vld,
  input  logic [IDX_W-1:0]           ins_idx,
  input  logic [NUM_SRC*TAG_W-1:0]   ins_src_tag,
  input  logic [NUM_SRC-1:0]         ins_src_rdy,
  input  logic                       ins_dst_vld,
  input  logic [TAG_W-1:0]           ins_dst_tag,
  input  logic [NUM_CMP-1:0]         cmp_vld,
  input  logic [NUM_CMP*TAG_W-1:0]   cmp_tag,
  input  logic [NUM_ENT-1:0]         squash,
  output logic [NUM_ENT*NUM_SRC-1:0] src_rdy,
  output logic [NUM_ENT-1:0]         ent_rdy,
  output logic [CNT_W-1:0]           wake_cnt,
  output logic                       prod_err
);
  localparam int PR_W = $clog2(NUM_PREGS);

  function automatic logic trk(input logic [TAG_W-1:0] t);
    return int'(t) < NUM_PREGS;
  endfunction

  logic [NUM_PREGS-1:0] sb, cmp_set, dst_clr;
  logic [NUM_ENT-1:0] vld;
  logic [NUM_ENT-1:0][NUM_SRC-1:0][TAG_W-1:0] tag;
  logic [NUM_ENT-1:0][NUM_SRC-1:0] wt, wake, dep_left;
  logic [NUM_SRC-1:0] nw;

  always_comb begin
    cmp_set = '0;
    for (int k = 0; k < NUM_CMP; k++)
      if (cmp_vld[k] && trk(cmp_tag[k*TAG_W +: TAG_W]))
        cmp_set[cmp_tag[k*TAG_W +: PR_W]] = 1'b1;
    dst_clr = '0;
    if (ins_vld && ins_dst_vld && trk(ins_dst_tag))
      dst_clr[ins_dst_tag[PR_W-1:0]] = 1'b1;
  end

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      nw[s] = trk(ins_src_tag[s*TAG_W +: TAG_W]) && !ins_src_rdy[s] &&
              !sb[ins_src_tag[s*TAG_W +: PR_W]] && !cmp_set[ins_src_tag[s*TAG_W +: PR_W]];
    end
    for (int e = 0; e < NUM_ENT; e++)
      for (int s = 0; s < NUM_SRC; s++) begin
        wake[e][s] = vld[e] && wt[e][s] && trk(tag[e][s]) && cmp_set[tag[e][s][PR_W-1:0]];
        dep_left[e][s] = vld[e] && wt[e][s] && !wake[e][s] && !squash[e] &&
                         (tag[e][s] == ins_dst_tag);
      end
  end

  always_comb begin
    wake_cnt = '0;
    for (int e = 0; e < NUM_ENT; e++)
      wake_cnt = wake_cnt + CNT_W'(|wake[e]);
  end

  assign prod_err = ins_vld && ins_dst_vld && trk(ins_dst_tag) && |dep_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb  <= '0;
      vld <= '0;
      wt  <= '0;
      tag <= '0;
    end else begin
      sb <= (sb | cmp_set) & ~dst_clr;
      for (int e = 0; e < NUM_ENT; e++) begin
        if (ins_vld && ins_idx == IDX_W'(e)) begin
          vld[e] <= 1'b1;
          wt[e]  <= nw;
          for (int s = 0; s < NUM_SRC; s++)
            tag[e][s] <= ins_src_tag[s*TAG_W +: TAG_W];
        end else if (squash[e]) begin
          vld[e] <= 1'b0;
          wt[e]  <= '0;
        end else begin
          wt[e] <= wt[e] & ~wake[e];
        end
      end
    end
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_out
    assign ent_rdy[e] = vld[e] && !(|wt[e]);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign src_rdy[e*NUM_SRC+s] = vld[e] && !wt[e][s];
    end
  end
endmodule

// File: rtl/wakeup_scoreboard_chk.sv
module wakeup_scoreboard_chk #(
  parameter int NUM_PREGS = 16,
  parameter int NUM_ENT   = 8,
  parameter int NUM_SRC   = 2,
  parameter int NUM_CMP   = 2,
  localparam int TAG_W = $clog2(NUM_PREGS) + 1,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int CNT_W = $clog2(NUM_ENT + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ins_vld,
  input logic [IDX_W-1:0]           ins_idx,
  input logic                       ins_dst_vld,
  input logic [TAG_W-1:0]           ins_dst_tag,
  input logic [NUM_CMP-1:0]         cmp_vld,
  input logic [NUM_CMP*TAG_W-1:0]   cmp_tag,
  input logic [NUM_ENT-1:0]         squash,
  input logic [NUM_ENT*NUM_SRC-1:0] src_rdy,
  input logic [NUM_ENT-1:0]         ent_rdy,
  input logic [CNT_W-1:0]           wake_cnt,
  input logic [NUM_PREGS-1:0]       sb,
  input logic [NUM_ENT-1:0][NUM_SRC-1:0][TAG_W-1:0] tag,
  input logic [NUM_ENT-1:0][NUM_SRC-1:0] wt
);
  localparam int PR_W = $clog2(NUM_PREGS);

  function automatic logic trk(input logic [TAG_W-1:0] t);
    return int'(t) < NUM_PREGS;
  endfunction

  logic dst_on;
  assign dst_on = ins_vld && ins_dst_vld && trk(ins_dst_tag);

  // R2
  dst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_on |=> !sb[$past(ins_dst_tag[PR_W-1:0])]);

  // R10
  wake_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wake_cnt) <= NUM_ENT);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    // R5
    sb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld[k] && trk(cmp_tag[k*TAG_W +: TAG_W]) &&
       !(dst_on && ins_dst_tag == cmp_tag[k*TAG_W +: TAG_W]))
      |=> sb[$past(cmp_tag[k*TAG_W +: PR_W])]);
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic keep;
    assign keep = !squash[e] && !(ins_vld && ins_idx == IDX_W'(e));
    // R9
    ent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_rdy[e] && keep) |=> ent_rdy[e]);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      // R4
      untracked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wt[e][s] |-> trk(tag[e][s]));
      for (genvar k = 0; k < NUM_CMP; k++) begin : g_k
        // R5
        wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wt[e][s] && keep && cmp_vld[k] && trk(tag[e][s]) &&
           cmp_tag[k*TAG_W +: TAG_W] == tag[e][s])
          |=> src_rdy[e*NUM_SRC+s]);
      end
    end
  end
endmodule

bind wakeup_scoreboard wakeup_scoreboard_chk #(
  .NUM_PREGS(NUM_PREGS), .NUM_ENT(NUM_ENT), .NUM_SRC(NUM_SRC), .NUM_CMP(NUM_CMP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_idx(ins_idx),
  .ins_dst_vld(ins_dst_vld), .ins_dst_tag(ins_dst_tag), .cmp_vld(cmp_vld),
  .cmp_tag(cmp_tag), .squash(squash), .src_rdy(src_rdy), .ent_rdy(ent_rdy),
  .wake_cnt(wake_cnt), .sb(sb), .tag(tag), .wt(wt)
);

// File: tb/wakeup_scoreboard_tb_top.sv
module wakeup_scoreboard_tb_top;
  localparam int NP = 16, NE = 8, NS = 2, NC = 2, TW = 5, IW = 3, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ins_vld, ins_dst_vld;
  logic [IW-1:0] ins_idx;
  logic [NS*TW-1:0] ins_src_tag;
  logic [NS-1:0] ins_src_rdy;
  logic [TW-1:0] ins_dst_tag;
  logic [NC-1:0] cmp_vld;
  logic [NC*TW-1:0] cmp_tag;
  logic [NE-1:0] squash;
  logic [NE*NS-1:0] src_rdy;
  logic [NE-1:0] ent_rdy;
  logic [CW-1:0] wake_cnt;
  logic prod_err;

  wakeup_scoreboard dut_i (.*);

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit m_vld [NE];
  int m_tag [NE][NS];
  bit m_wt  [NE][NS];
  bit m_sb  [NP];

  function automatic bit hit(int t);
    bit h = 0;
    for (int k = 0; k < NC; k++)
      if (cmp_vld[k] && int'(cmp_tag[k*TW +: TW]) == t && t < NP) h = 1;
    return h;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ins_vld = 0; ins_idx = '0; ins_src_tag = '0; ins_src_rdy = '0;
    ins_dst_vld = 0; ins_dst_tag = '0; cmp_vld = '0; cmp_tag = '0; squash = '0;
  endtask

  task automatic step();
    logic [NE*NS-1:0] e_src; logic [NE-1:0] e_ent;
    int e_wc; bit e_err; bit wk [NE][NS]; bit nw [NS]; int d;
    #1;
    e_wc = 0; e_err = 0; e_ent = '0; e_src = '0;
    for (int e = 0; e < NE; e++) begin
      bit any = 0, allr = 1;
      for (int s = 0; s < NS; s++) begin
        wk[e][s] = m_vld[e] && m_wt[e][s] && hit(m_tag[e][s]);
        if (wk[e][s]) any = 1;
        if (m_wt[e][s]) allr = 0;
        e_src[e*NS+s] = m_vld[e] && !m_wt[e][s];
        if (m_vld[e] && m_wt[e][s] && !wk[e][s] && !squash[e] &&
            m_tag[e][s] == int'(ins_dst_tag)) e_err = 1;
      end
      if (any) e_wc++;
      e_ent[e] = m_vld[e] && allr;
    end
    if (!(ins_vld && ins_dst_vld && int'(ins_dst_tag) < NP)) e_err = 0;
    chk(cur_req, "src_rdy", longint'(src_rdy), longint'(e_src));
    chk("R9", "ent_rdy", longint'(ent_rdy), longint'(e_ent));
    chk("R10", "wake_cnt", longint'(wake_cnt), longint'(e_wc));
    chk("R7", "prod_err", longint'(prod_err), longint'(e_err));
    for (int s = 0; s < NS; s++) begin
      int t = int'(ins_src_tag[s*TW +: TW]);
      nw[s] = t < NP && !ins_src_rdy[s] && !m_sb[t < NP ? t : 0] && !hit(t);
    end
    for (int e = 0; e < NE; e++) begin
      if (ins_vld && int'(ins_idx) == e) begin
        m_vld[e] = 1;
        for (int s = 0; s < NS; s++) begin
          m_wt[e][s] = nw[s]; m_tag[e][s] = int'(ins_src_tag[s*TW +: TW]);
        end
      end else if (squash[e]) begin
        m_vld[e] = 0;
        for (int s = 0; s < NS; s++) m_wt[e][s] = 0;
      end else
        for (int s = 0; s < NS; s++) if (wk[e][s]) m_wt[e][s] = 0;
    end
    for (int k = 0; k < NC; k++) begin
      d = int'(cmp_tag[k*TW +: TW]);
      if (cmp_vld[k] && d < NP) m_sb[d] = 1;
    end
    d = int'(ins_dst_tag);
    if (ins_vld && ins_dst_vld && d < NP) m_sb[d] = 0;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic ins(int idx, int t0, int t1, bit r0, bit r1, bit dv, int dt);
    ins_vld = 1; ins_idx = IW'(idx);
    ins_src_tag = {TW'(t1), TW'(t0)}; ins_src_rdy = {r1, r0};
    ins_dst_vld = dv; ins_dst_tag = TW'(dt);
  endtask

  task automatic cmp(int lane, int t);
    cmp_vld[lane] = 1; cmp_tag[lane*TW +: TW] = TW'(t);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    for (int e = 0; e < NE; e++) begin
      m_vld[e] = 0;
      for (int s = 0; s < NS; s++) begin m_wt[e][s] = 0; m_tag[e][s] = 0; end
    end
    for (int r = 0; r < NP; r++) m_sb[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, then scoreboard starts not-ready
    cur_req = "R1"; step();
    ins(0, 3, 4, 0, 0, 1, 12); step();
    step();
    chk("R1", "src_rdy after reset insert", longint'(src_rdy[1:0]), 0);
    // R5: completions wake sources
    cur_req = "R5"; cmp(0, 3); step(); step();
    chk("R5", "entry0 src0 woken", longint'(src_rdy[1:0]), 2'b01);
    cmp(1, 4); step(); step();
    chk("R9", "entry0 fully ready", longint'(ent_rdy[0]), 1);
    // R3: scoreboard catch and rename hint
    cur_req = "R3"; ins(1, 3, 7, 0, 1, 0, 0); step(); step();
    chk("R3", "entry1 ready at insert", longint'(src_rdy[3:2]), 2'b11);
    // R4: untracked tags
    cur_req = "R4"; ins(2, 20, 31, 0, 0, 1, 25); step();
    cmp(0, 20); cmp(1, 25); step(); step();
    chk("R4", "untracked sources ready", longint'(src_rdy[5:4]), 2'b11);
    // R2: destination clears the scoreboard, wins over completion
    cur_req = "R2"; ins(3, 7, 7, 1, 1, 1, 3); step();
    ins(4, 3, 9, 0, 1, 0, 0); step(); step();
    chk("R2", "entry4 waits on cleared reg", longint'(src_rdy[8]), 0);
    ins(5, 0, 0, 1, 1, 1, 9); cmp(0, 9); step();
    ins(6, 9, 9, 0, 0, 0, 0); step(); step();
    chk("R2", "clear beats completion", longint'(src_rdy[13:12]), 0);
    // R6: same-cycle bypass
    cur_req = "R6"; ins(7, 10, 11, 0, 1, 0, 0); cmp(1, 10); step(); step();
    chk("R6", "bypass ready", longint'(src_rdy[15:14]), 2'b11);
    // R7: producer with remaining dependents
    cur_req = "R7"; ins(3, 7, 7, 1, 1, 1, 3); #1;
    chk("R7", "prod_err raised", longint'(prod_err), 1);
    step();
    ins(3, 7, 7, 1, 1, 1, 3); squash[4] = 1; #1;
    chk("R8", "squashed dependent no error", longint'(prod_err), 0);
    step();
    // R8: squash removes entry
    cur_req = "R8"; step();
    chk("R8", "entry4 invalid", longint'(src_rdy[9:8]), 0);
    cmp(0, 3); step(); step();
    // R10: two lanes waking several entries
    cur_req = "R10"; squash = 8'hff; step();
    ins(0, 13, 14, 0, 0, 1, 1); step();
    ins(1, 13, 2, 0, 1, 1, 2); step();
    ins(2, 14, 14, 0, 0, 1, 4); step();
    cmp(0, 13); cmp(1, 14); #1;
    chk("R10", "three entries woken", longint'(wake_cnt), 3);
    step(); step();
    chk("R10", "all ready", longint'(ent_rdy[2:0]), 3'b111);
    // randomized traffic against the model
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 1)
        ins($urandom_range(0, NE-1), $urandom_range(0, 19), $urandom_range(0, 19),
            $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 19));
      if ($urandom_range(0, 1) == 1) cmp(0, $urandom_range(0, 19));
      if ($urandom_range(0, 2) == 0) cmp(1, $urandom_range(0, 19));
      if ($urandom_range(0, 5) == 0) squash = NE'($urandom_range(0, 255));
      step();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule